// File: doc/BRIEF.md
# Serial-Loaded Four-Latch Register Bank

This block is the programming front end of a clock synthesiser. A host drives three slow pins (a serial clock, a serial data line and a load strobe), and the block oversamples them on a fast system clock. Data bits enter a 24-bit shift register, most significant bit first. A rising edge on the load strobe copies the upper 22 bits of the word into one of four holding latches. The two least significant bits of the word pick the latch.

The held values appear as parallel fields: a 14-bit reference divider, a 13-bit feedback divider, a 2-bit output-select code with a software power-down bit, and a 22-bit auxiliary word. The chip-enable pin is combined with the software power-down bit to give a power-down flag and a charge-pump enable flag. The output-select code steers one of three monitor signals onto a single output pin.

Top module: `sprog_bank_top`

## Requirements
- R1: After reset, ref_div, fb_div, mux_sel and aux_word are all zero, and the software power-down bit is clear.
- R2: On each rising edge of the synchronized serial clock, while the load strobe is low, the shift register takes in the data bit at bit 0, shifting the word MSB first. Word bits [1:0] select the destination: 0 = reference latch, 1 = feedback latch, 2 = function latch, 3 = auxiliary latch.
- R3: A rising edge of the load strobe commits the word to the selected latch. The reference latch takes ref_div from word bits [15:2].
- R4: The feedback latch takes fb_div from word bits [14:2]. A value of 1 is held and output unchanged.
- R5: The function latch takes mux_sel from word bits [3:2] and the software power-down bit from word bit 4.
- R6: The auxiliary latch takes aux_word from word bits [23:2].
- R7: If more than 24 bits arrive before a load strobe, only the last 24 received are kept.
- R8: Serial clock edges that arrive while the load strobe is high do not change the shift register.
- R9: While chip_en is low, power_down is 1 and cp_enable is 0. While chip_en is high, power_down equals the software power-down bit and cp_enable is its inverse.
- R10: mux_out follows lock_det when mux_sel is 0, ref_scaled when it is 1 and fb_scaled when it is 2. When mux_sel is 3, mux_out is driven low.
- R11: A commit changes only the selected latch. The other three keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock pin, asynchronous |
| ser_data | input | 1 | Serial data pin, asynchronous |
| ser_load | input | 1 | Load strobe pin, asynchronous |
| chip_en | input | 1 | Chip enable pin, asynchronous |
| lock_det | input | 1 | Lock indication for the output mux |
| ref_scaled | input | 1 | Scaled reference for the output mux |
| fb_scaled | input | 1 | Scaled feedback for the output mux |
| ref_div | output | 14 | Reference divider value |
| fb_div | output | 13 | Feedback divider value |
| mux_sel | output | 2 | Output-select code |
| aux_word | output | 22 | Auxiliary latch contents |
| power_down | output | 1 | Power-down flag |
| cp_enable | output | 1 | Charge-pump output enable |
| mux_out | output | 1 | Selected monitor signal |

## Verification
The hardest case to reach from the pins is a serial clock edge that arrives while the load strobe is still high. If such an edge were wrongly accepted, the last bits of the shift register would change without any visible effect until the next commit. To expose it, the bench holds the strobe high and clocks in several ones. It then drops the strobe and pulses it again with no new data. The same latch must be rewritten with the same value, and the auxiliary latch, which a shifted-in control code of 3 would select, must stay untouched. Overlong words are covered the same way: 26 bits are sent and the result of the commit is checked.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
   localparam int unsigned WORD_W = 24;
   localparam int unsigned CTRL_W = 2;
   localparam int unsigned REF_W  = 14;
   localparam int unsigned FB_W   = 13;
   localparam int unsigned SEL_W  = 2;

   typedef enum logic [1:0] {
      DST_REF  = 2'd0,
      DST_FB   = 2'd1,
      DST_FUNC = 2'd2,
      DST_AUX  = 2'd3
   } dest_e;

   typedef enum logic [1:0] {
      MX_LOCK = 2'd0,
      MX_REF  = 2'd1,
      MX_FB   = 2'd2,
      MX_LOW  = 2'd3
   } mux_e;
endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sprog_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= din;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[k] <= '0;
         else        chain[k] <= chain[k-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/sprog_shifter.sv
module sprog_shifter #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              din,
   output logic [WORD_W-1:0] word
);
   if (WORD_W < 4) begin : g_bad_width
      $error("sprog_shifter: WORD_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= {word[WORD_W-2:0], din};
   end

   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(word));
   // R2
   msb_first_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (word[0] == $past(din)) && (word[WORD_W-1:1] == $past(word[WORD_W-2:0])));
endmodule

// File: rtl/sprog_latches.sv
module sprog_latches
   import sprog_pkg::*;
#(
   parameter int unsigned PAY_W  = 22,
   parameter int unsigned CTRL_W = 2,
   parameter int unsigned REF_W  = 14,
   parameter int unsigned FB_W   = 13,
   parameter int unsigned SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CTRL_W-1:0] dest,
   input  logic [PAY_W-1:0]  payload,
   output logic [REF_W-1:0]  ref_q,
   output logic [FB_W-1:0]   fb_q,
   output logic [SEL_W-1:0]  sel_q,
   output logic              pd_q,
   output logic [PAY_W-1:0]  aux_q
);
   localparam int unsigned N_DST = 1 << CTRL_W;

   if (REF_W > PAY_W || FB_W > PAY_W || SEL_W + 1 > PAY_W) begin : g_bad_fields
      $error("sprog_latches: field wider than payload");
   end
   if (N_DST != 4) begin : g_bad_count
      $error("sprog_latches: exactly four destinations are supported");
   end

   logic [N_DST-1:0] wr;
   for (genvar i = 0; i < N_DST; i++) begin : g_dec
      assign wr[i] = load && (dest == CTRL_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
         fb_q  <= '0;
         sel_q <= '0;
         pd_q  <= 1'b0;
         aux_q <= '0;
      end else begin
         if (wr[DST_REF])  ref_q <= payload[REF_W-1:0];
         if (wr[DST_FB])   fb_q  <= payload[FB_W-1:0];
         if (wr[DST_FUNC]) begin
            sel_q <= payload[SEL_W-1:0];
            pd_q  <= payload[SEL_W];
         end
         if (wr[DST_AUX])  aux_q <= payload;
      end
   end

   // R11
   idle_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(ref_q) && $stable(fb_q) && $stable(sel_q) && $stable(pd_q) && $stable(aux_q));
   // R11
   ref_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && dest == CTRL_W'(DST_REF)) |=> $stable(fb_q) && $stable(sel_q) && $stable(aux_q)
         && ref_q == $past(payload[REF_W-1:0]));
   // R6
   aux_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && dest == CTRL_W'(DST_AUX)) |=> aux_q == $past(payload) && $stable(ref_q));
endmodule

// File: rtl/sprog_bank_top.sv
module sprog_bank_top
   import sprog_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_data,
   input  logic               ser_load,
   input  logic               chip_en,
   input  logic               lock_det,
   input  logic               ref_scaled,
   input  logic               fb_scaled,
   output logic [REF_W-1:0]   ref_div,
   output logic [FB_W-1:0]    fb_div,
   output logic [SEL_W-1:0]   mux_sel,
   output logic [WORD_W-CTRL_W-1:0] aux_word,
   output logic               power_down,
   output logic               cp_enable,
   output logic               mux_out
);
   localparam int unsigned PAY_W = WORD_W - CTRL_W;

   logic [3:0] pins_s;
   logic       sclk_s, sdat_s, load_s, ce_s;
   logic       sclk_d, load_d;
   logic       shift_en, load_rise;
   logic [WORD_W-1:0] word;
   logic       sw_pd;

   sprog_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({chip_en, ser_load, ser_data, ser_clk}),
      .dout (pins_s)
   );
   assign {ce_s, load_s, sdat_s, sclk_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         load_d <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         load_d <= load_s;
      end
   end

   assign shift_en  = sclk_s && !sclk_d && !load_s;
   assign load_rise = load_s && !load_d;

   sprog_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .din     (sdat_s),
      .word    (word)
   );

   sprog_latches #(
      .PAY_W (PAY_W),
      .CTRL_W(CTRL_W),
      .REF_W (REF_W),
      .FB_W  (FB_W),
      .SEL_W (SEL_W)
   ) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_rise),
      .dest   (word[CTRL_W-1:0]),
      .payload(word[WORD_W-1:CTRL_W]),
      .ref_q  (ref_div),
      .fb_q   (fb_div),
      .sel_q  (mux_sel),
      .pd_q   (sw_pd),
      .aux_q  (aux_word)
   );

   assign power_down = !ce_s || sw_pd;
   assign cp_enable  = !power_down;

   always_comb begin
      unique case (mux_e'(mux_sel))
         MX_LOCK: mux_out = lock_det;
         MX_REF:  mux_out = ref_scaled;
         MX_FB:   mux_out = fb_scaled;
         default: mux_out = 1'b0;
      endcase
   end

   // R10
   mux_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_sel == 2'd3) |-> !mux_out);
   // R9
   flags_opposed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      power_down != cp_enable);

   if (SYNC_STAGES == 2) begin : g_ce_chk
      // R9
      ce_forces_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(chip_en, 2) |-> power_down && !cp_enable);
   end
endmodule

// File: tb/sim_sprog_bank_top.sv
`timescale 1ns/1ps
module sim_sprog_bank_top;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, chip_en = 1'b1;
   logic lock_det = 1'b0, ref_scaled = 1'b0, fb_scaled = 1'b0;
   logic [13:0] ref_div;
   logic [12:0] fb_div;
   logic [1:0]  mux_sel;
   logic [21:0] aux_word;
   logic        power_down, cp_enable, mux_out;

   sprog_bank_top u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load(ser_load), .chip_en(chip_en), .lock_det(lock_det),
      .ref_scaled(ref_scaled), .fb_scaled(fb_scaled), .ref_div(ref_div),
      .fb_div(fb_div), .mux_sel(mux_sel), .aux_word(aux_word),
      .power_down(power_down), .cp_enable(cp_enable), .mux_out(mux_out)
   );

   int checks = 0;
   int errors = 0;

   typedef struct {
      string       tag;
      logic [13:0] r;
      logic [12:0] f;
      logic [1:0]  s;
      logic        p;
      logic [21:0] a;
   } exp_t;
   exp_t q[$];

   logic [23:0] m_sh = '0;
   logic [13:0] m_ref = '0;
   logic [12:0] m_fb = '0;
   logic [1:0]  m_sel = '0;
   logic        m_pd = 1'b0;
   logic [21:0] m_aux = '0;
   logic        done = 1'b0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put_bit(logic b);
      @(negedge clk);
      ser_data = b;
      repeat (6) @(negedge clk);
      ser_clk = 1'b1;
      repeat (6) @(negedge clk);
      ser_clk = 1'b0;
      if (!ser_load) m_sh = {m_sh[22:0], b};
   endtask

   task automatic send(logic [31:0] v, int n);
      for (int i = n - 1; i >= 0; i--) put_bit(v[i]);
   endtask

   // commit; extra_ones are serial clock edges issued while the strobe is high
   task automatic strobe(string tag, int extra_ones);
      @(negedge clk);
      ser_load = 1'b1;
      case (m_sh[1:0])
         2'd0: m_ref = m_sh[15:2];
         2'd1: m_fb  = m_sh[14:2];
         2'd2: begin m_sel = m_sh[3:2]; m_pd = m_sh[4]; end
         default: m_aux = m_sh[23:2];
      endcase
      repeat (6) @(negedge clk);
      for (int i = 0; i < extra_ones; i++) put_bit(1'b1);
      ser_load = 1'b0;
      q.push_back('{tag, m_ref, m_fb, m_sel, m_pd, m_aux});
      repeat (14) @(negedge clk);
   endtask

   // monitor: pops an expected set once the design has had time to commit
   initial begin
      forever begin
         wait (q.size() > 0);
         repeat (8) @(negedge clk);
         begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " ref_div"},  32'(ref_div),  32'(e.r));
            chk({e.tag, " fb_div"},   32'(fb_div),   32'(e.f));
            chk({e.tag, " mux_sel"},  32'(mux_sel),  32'(e.s));
            chk({e.tag, " power_down"}, 32'(power_down), 32'(e.p));
            chk({e.tag, " aux_word"}, 32'(aux_word), 32'(e.a));
         end
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         finish_run();
      end
   end

   task automatic mux_case(logic [1:0] code);
      send({22'(code), 2'd2}, 24);
      strobe("R5 mux", 0);
      repeat (10) @(negedge clk);
      lock_det = 1'b1; ref_scaled = 1'b0; fb_scaled = 1'b0; #1;
      chk("R10 lock pattern", 32'(mux_out), 32'(code == 2'd0));
      lock_det = 1'b0; ref_scaled = 1'b1; fb_scaled = 1'b0; #1;
      chk("R10 ref pattern", 32'(mux_out), 32'(code == 2'd1));
      lock_det = 1'b0; ref_scaled = 1'b0; fb_scaled = 1'b1; #1;
      chk("R10 fb pattern", 32'(mux_out), 32'(code == 2'd2));
      lock_det = 1'b1; ref_scaled = 1'b1; fb_scaled = 1'b1; #1;
      chk("R10 all high", 32'(mux_out), 32'(code != 2'd3));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 ref_div", 32'(ref_div), 0);
      chk("R1 fb_div", 32'(fb_div), 0);
      chk("R1 mux_sel", 32'(mux_sel), 0);
      chk("R1 aux_word", 32'(aux_word), 0);
      chk("R1 power_down", 32'(power_down), 0);
      chk("R1 cp_enable", 32'(cp_enable), 1);

      // R2 R3 reference latch
      send({8'h00, 14'h2ABC, 2'd0}, 24);
      strobe("R3 ref", 0);
      // R4 feedback of one, then all ones
      send({9'h000, 13'h0001, 2'd1}, 24);
      strobe("R4 fb=1", 0);
      send({9'h1A5, 13'h1FFF, 2'd1}, 24);
      strobe("R4 fb max", 0);
      // R5 function latch, software power-down set
      send({19'h0, 1'b1, 2'd2, 2'd2}, 24);
      strobe("R5 func", 0);
      repeat (10) @(negedge clk);
      chk("R9 sw pd power_down", 32'(power_down), 1);
      chk("R9 sw pd cp_enable", 32'(cp_enable), 0);
      // R6 auxiliary latch
      send(32'h00A5A5A7, 24);
      strobe("R6 aux", 0);
      // R7 overlong word: two leading ones must fall off
      send({6'h0, 2'b11, 8'h00, 14'h0123, 2'd0}, 26);
      strobe("R7 overlong", 0);
      // R8 edges during strobe are ignored, then a bare re-strobe
      send({8'h00, 14'h1357, 2'd0}, 24);
      strobe("R8 first", 3);
      strobe("R8 restrobe", 0);
      // R10 output mux codes
      for (int c = 0; c < 4; c++) mux_case(2'(c));
      // R9 chip enable
      send({19'h0, 1'b0, 2'd0, 2'd2}, 24);
      strobe("R9 pd clear", 0);
      repeat (10) @(negedge clk);
      chk("R9 ce high pd clear", 32'(power_down), 0);
      chip_en = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 ce low power_down", 32'(power_down), 1);
      chk("R9 ce low cp_enable", 32'(cp_enable), 0);
      chip_en = 1'b1;
      repeat (5) @(negedge clk);
      chk("R9 ce high cp_enable", 32'(cp_enable), 1);

      wait (q.size() == 0);
      repeat (12) @(negedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule